// File: doc/BRIEF.md
# Second-Level Cache Control and Command Unit

This block is the register-mapped control point of a shared second-level cache. A 32-bit register port carries a byte address, a write strobe, write data and combinational read data. The block turns register writes into steady configuration outputs for the cache datapath: an enable for cacheable accesses, an enable for allocation on reads, and a limit on outstanding reads. It also turns writes into one-cycle invalidate requests, either for the whole cache or for a single page.

A single command handler accepts one invalidate at a time. While a request is in flight, a busy flag is set and further requests are discarded. The datapath ends the request by raising a done input. Two event counters are also provided. Each one watches a single bit of an event vector, picked by its own source register. A counter restarts whenever its source is rewritten or a zero is written to its value register, and it stops at its largest value.

Top module: `l2c_ctrl`

## Requirements
- R1: After reset the enable outputs are 0, the outstanding-read limit is 0x1C, both counts and both sources are 0, the held page number is 0, no pulse is driven, and status reads 0 while data-busy is low.
- R2: The register index is byte address bits [ADDR_W-1:2], and address bits [1:0] are ignored. The map is: status 2, command 4, page 5, read limit 6, enable 7, source A 8, count A 9, source B 10, count B 11. The command index reads 0. Index 3 and any index outside the map read 0 and ignore writes. Writes to status have no effect.
- R3: Status bit 0 is the command-busy flag and status bit 1 follows data_busy_i. The other status bits read 0.
- R4: When the handler is idle, writing exactly 0x01 to the command index raises flush_all_o for one cycle, starting in the cycle after the write. Busy is set in that same cycle. Any other command value is ignored.
- R5: When the handler is idle, a write to the page index raises flush_page_o for one cycle in the cycle after the write, and sets busy. flush_page_num_o takes write data bits [PAGE_W-1:0] and holds them until the next accepted page write. The page index reads back this held value.
- R6: A command or page write that arrives in a cycle where busy is set is discarded. It produces no pulse and no page change.
- R7: Busy clears in the cycle after flush_done_i is seen high while busy is set. When busy is clear, flush_done_i has no effect.
- R8: Enable index bit 0 drives access_en_o and bit 1 drives read_alloc_en_o. The register reads back these two bits, and its other bits are discarded.
- R9: The read-limit index stores write data bits [MAXR_W-1:0]. It drives max_reads_o and reads back zero-extended.
- R10: In each cycle, a counter adds 1 when event_i bit N is high, where N is its source value. A source value of EV_N or more counts nothing. The count reads back zero-extended.
- R11: Any write to a counter's source index, or a write of 0 to its count index, sets that count to 0 and ignores that cycle's event. A nonzero write to a count index is ignored.
- R12: A count that reaches all ones in CNT_W bits stays there until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| access_en_o | output | 1 | Cacheable accesses permitted |
| read_alloc_en_o | output | 1 | Read allocation permitted |
| max_reads_o | output | MAXR_W | Outstanding read limit |
| flush_all_o | output | 1 | One-cycle request to invalidate the whole cache |
| flush_page_o | output | 1 | One-cycle request to invalidate one page |
| flush_page_num_o | output | PAGE_W | Page number of the last accepted page request |
| flush_done_i | input | 1 | Datapath has finished the current invalidate |
| data_busy_i | input | 1 | Datapath is serving data requests |
| event_i | input | EV_N | Event vector sampled by the counters |

## Verification
A stuck or stale busy flag shows up in the cycle after the next command write: a pulse is either missing or appears when it should not. The status read exposes the flag at once. A counter that increments on the wrong bit, misses a clear, or wraps past all ones shows up on its value read in the same cycle it goes wrong, because the bench reads a count register on nearly every counting cycle. A page register that moves while busy, or a corrupted configuration field, is visible on the output ports in the cycle after the offending write.

// File: rtl/l2c_ctrl_pkg.sv
`timescale 1ns/1ps
package l2c_ctrl_pkg;
  typedef enum logic [3:0] {
    IDX_STATUS = 4'd2,
    IDX_CMD    = 4'd4,
    IDX_PAGE   = 4'd5,
    IDX_MAXRD  = 4'd6,
    IDX_ENABLE = 4'd7,
    IDX_SRC0   = 4'd8,
    IDX_VAL0   = 4'd9,
    IDX_SRC1   = 4'd10,
    IDX_VAL1   = 4'd11
  } reg_idx_e;

  localparam logic [31:0] CMD_FLUSH_ALL = 32'h1;
  localparam int unsigned NUM_CNT       = 2;
  localparam logic [7:0]  MAXRD_RST     = 8'h1C;
endpackage

// File: rtl/l2c_ctrl_cmd.sv
`timescale 1ns/1ps
module l2c_ctrl_cmd
  import l2c_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              page_we_i,
  input  logic [31:0]       wdata_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              flush_all_o,
  output logic              flush_page_o,
  output logic [PAGE_W-1:0] page_o
);
  logic              busy_q, all_q, pg_q;
  logic [PAGE_W-1:0] page_q;
  logic              take_all, take_pg;

  // requests are only taken while idle; busy requests vanish
  assign take_all = cmd_we_i && (wdata_i == CMD_FLUSH_ALL) && !busy_q;
  assign take_pg  = page_we_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      all_q  <= 1'b0;
      pg_q   <= 1'b0;
      page_q <= '0;
    end else begin
      if (busy_q) busy_q <= !done_i;
      else        busy_q <= take_all || take_pg;
      all_q <= take_all;
      pg_q  <= take_pg;
      if (take_pg) page_q <= wdata_i[PAGE_W-1:0];
    end
  end

  assign busy_o       = busy_q;
  assign flush_all_o  = all_q;
  assign flush_page_o = pg_q;
  assign page_o       = page_q;

  AST_PULSE_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_o || flush_page_o) |-> busy_q); // R4
  AST_ALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |=> !flush_all_o); // R4
  AST_PAGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_page_o |=> !flush_page_o); // R5
  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(page_q)); // R5
  AST_NO_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !(flush_all_o || flush_page_o)); // R6
  AST_BUSY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q); // R7
endmodule

// File: rtl/l2c_ctrl_evcnt.sv
`timescale 1ns/1ps
module l2c_ctrl_evcnt #(
  parameter int unsigned EV_N  = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            src_we_i,
  input  logic            val_we_i,
  input  logic [31:0]     wdata_i,
  input  logic [EV_N-1:0] event_i,
  output logic [31:0]     src_o,
  output logic [31:0]     cnt_o
);
  localparam int unsigned SEL_W = (EV_N > 1) ? $clog2(EV_N) : 1;

  logic [31:0]      src_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clr, in_range, hit, at_max;

  assign clr      = src_we_i || (val_we_i && (wdata_i == 32'd0));
  assign in_range = (src_q < 32'(EV_N));
  assign hit      = in_range && event_i[src_q[SEL_W-1:0]];
  assign at_max   = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_we_i) src_q <= wdata_i;
      if (clr)                 cnt_q <= '0;
      else if (hit && !at_max) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign src_o = src_q;
  assign cnt_o = 32'(cnt_q);

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && !clr) |=> (&cnt_q)); // R12
  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> (cnt_q >= $past(cnt_q))); // R10
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/l2c_ctrl.sv
`timescale 1ns/1ps
module l2c_ctrl
  import l2c_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned MAXR_W = 8,
  parameter int unsigned EV_N   = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              access_en_o,
  output logic              read_alloc_en_o,
  output logic [MAXR_W-1:0] max_reads_o,
  output logic              flush_all_o,
  output logic              flush_page_o,
  output logic [PAGE_W-1:0] flush_page_num_o,
  input  logic              flush_done_i,
  input  logic              data_busy_i,
  input  logic [EV_N-1:0]   event_i
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr_cmd, wr_page, wr_maxrd, wr_en;
  logic [1:0]        en_q;
  logic [MAXR_W-1:0] maxrd_q;
  logic              busy;
  logic [NUM_CNT-1:0] wr_src, wr_val;
  logic [31:0]       src_rd [NUM_CNT];
  logic [31:0]       cnt_rd [NUM_CNT];

  assign idx      = bus_addr_i[ADDR_W-1:2];
  assign wr_cmd   = bus_we_i && (idx == IDX_W'(IDX_CMD));
  assign wr_page  = bus_we_i && (idx == IDX_W'(IDX_PAGE));
  assign wr_maxrd = bus_we_i && (idx == IDX_W'(IDX_MAXRD));
  assign wr_en    = bus_we_i && (idx == IDX_W'(IDX_ENABLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 2'b00;
      maxrd_q <= MAXR_W'(MAXRD_RST);
    end else begin
      if (wr_en)    en_q    <= bus_wdata_i[1:0];
      if (wr_maxrd) maxrd_q <= bus_wdata_i[MAXR_W-1:0];
    end
  end

  assign access_en_o     = en_q[0];
  assign read_alloc_en_o = en_q[1];
  assign max_reads_o     = maxrd_q;

  l2c_ctrl_cmd #(.PAGE_W(PAGE_W)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (wr_cmd),
    .page_we_i    (wr_page),
    .wdata_i      (bus_wdata_i),
    .done_i       (flush_done_i),
    .busy_o       (busy),
    .flush_all_o  (flush_all_o),
    .flush_page_o (flush_page_o),
    .page_o       (flush_page_num_o)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign wr_src[k] = bus_we_i && (idx == IDX_W'(32'(IDX_SRC0) + 2 * k));
    assign wr_val[k] = bus_we_i && (idx == IDX_W'(32'(IDX_VAL0) + 2 * k));
    l2c_ctrl_evcnt #(.EV_N(EV_N), .CNT_W(CNT_W)) u_evcnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_we_i (wr_src[k]),
      .val_we_i (wr_val[k]),
      .wdata_i  (bus_wdata_i),
      .event_i  (event_i),
      .src_o    (src_rd[k]),
      .cnt_o    (cnt_rd[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (idx == IDX_W'(IDX_STATUS)) bus_rdata_o = {30'd0, data_busy_i, busy};
    if (idx == IDX_W'(IDX_PAGE))   bus_rdata_o = 32'(flush_page_num_o);
    if (idx == IDX_W'(IDX_MAXRD))  bus_rdata_o = 32'(maxrd_q);
    if (idx == IDX_W'(IDX_ENABLE)) bus_rdata_o = {30'd0, en_q};
    for (int k = 0; k < NUM_CNT; k++) begin
      if (idx == IDX_W'(32'(IDX_SRC0) + 2 * k)) bus_rdata_o = src_rd[k];
      if (idx == IDX_W'(32'(IDX_VAL0) + 2 * k)) bus_rdata_o = cnt_rd[k];
    end
  end

  AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable({access_en_o, read_alloc_en_o})); // R8
  AST_MAXRD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_maxrd |=> $stable(max_reads_o)); // R9
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({flush_all_o, flush_page_o}) <= 1); // R6
endmodule

// File: tb/tb_l2c_ctrl.sv
`timescale 1ns/1ps
module tb_l2c_ctrl;
  localparam int ADDR_W = 6;
  localparam int PAGE_W = 20;
  localparam int MAXR_W = 8;
  localparam int EV_N   = 4;
  localparam int CNT_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic              bus_we_i = 1'b0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              access_en_o, read_alloc_en_o;
  logic [MAXR_W-1:0] max_reads_o;
  logic              flush_all_o, flush_page_o;
  logic [PAGE_W-1:0] flush_page_num_o;
  logic              flush_done_i = 1'b0;
  logic              data_busy_i = 1'b0;
  logic [EV_N-1:0]   event_i = '0;

  l2c_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MAXR_W(MAXR_W),
             .EV_N(EV_N), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .access_en_o(access_en_o), .read_alloc_en_o(read_alloc_en_o),
    .max_reads_o(max_reads_o), .flush_all_o(flush_all_o),
    .flush_page_o(flush_page_o), .flush_page_num_o(flush_page_num_o),
    .flush_done_i(flush_done_i), .data_busy_i(data_busy_i), .event_i(event_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit          m_busy, m_all, m_pg;
  logic [31:0] m_page, m_mr, m_en;
  logic [31:0] m_src [2];
  int          m_cnt [2];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int idx);
    case (idx)
      2:  return {30'd0, data_busy_i, m_busy};
      5:  return m_page;
      6:  return m_mr;
      7:  return m_en;
      8:  return m_src[0];
      9:  return 32'(m_cnt[0]);
      10: return m_src[1];
      11: return 32'(m_cnt[1]);
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    int idx = int'(bus_addr_i) / 4;
    bit was_busy = m_busy;
    m_all = 0;
    m_pg  = 0;
    if (was_busy && flush_done_i) m_busy = 0;
    if (!was_busy && bus_we_i && idx == 4 && bus_wdata_i == 32'h1) begin
      m_all = 1; m_busy = 1;
    end
    if (!was_busy && bus_we_i && idx == 5) begin
      m_pg = 1; m_busy = 1; m_page = bus_wdata_i & 32'hFFFFF;
    end
    if (bus_we_i && idx == 6) m_mr = bus_wdata_i & 32'hFF;
    if (bus_we_i && idx == 7) m_en = bus_wdata_i & 32'h3;
    for (int k = 0; k < 2; k++) begin
      if (bus_we_i && idx == 8 + 2 * k) begin
        m_src[k] = bus_wdata_i; m_cnt[k] = 0;
      end else if (bus_we_i && idx == 9 + 2 * k && bus_wdata_i == 0) begin
        m_cnt[k] = 0;
      end else if (m_src[k] < EV_N && event_i[m_src[k]] && m_cnt[k] < CMAX) begin
        m_cnt[k]++;
      end
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "flush_all", 32'(flush_all_o), 32'(m_all));
    chk(tag, "flush_page", 32'(flush_page_o), 32'(m_pg));
    chk(tag, "page_num", 32'(flush_page_num_o), m_page);
    chk(tag, "enables", {30'd0, read_alloc_en_o, access_en_o}, m_en);
    chk(tag, "max_reads", 32'(max_reads_o), m_mr);
    chk(tag, "rdata", bus_rdata_o, exp_rd(int'(bus_addr_i) / 4));
  endtask

  task automatic cyc(string tag, bit we, int idx, logic [31:0] wd,
                     bit done = 0, bit dbusy = 0, logic [EV_N-1:0] ev = '0, int low = 0);
    bus_we_i     = we;
    bus_addr_i   = ADDR_W'(idx * 4 + low);
    bus_wdata_i  = wd;
    flush_done_i = done;
    data_busy_i  = dbusy;
    event_i      = ev;
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare(tag);
  endtask

  function automatic logic [EV_N-1:0] next_ev();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[EV_N-1:0];
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    m_busy = 0; m_all = 0; m_pg = 0; m_page = 0; m_mr = 32'h1C; m_en = 0;
    m_src[0] = 0; m_src[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    bus_addr_i = ADDR_W'(6 * 4);
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    // R1 reset values
    cyc("R1", 0, 6, 0); cyc("R1", 0, 7, 0); cyc("R1", 0, 9, 0);
    cyc("R1", 0, 11, 0); cyc("R1", 0, 2, 0); cyc("R1", 0, 5, 0);
    // R8 enables
    cyc("R8", 1, 7, 3); cyc("R8", 1, 7, 2); cyc("R8", 1, 7, 32'hFFFF_FFFD);
    cyc("R8", 0, 7, 0);
    // R9 read limit
    cyc("R9", 1, 6, 32'h1234); cyc("R9", 0, 6, 0);
    // R2 decode, unused and status writes
    cyc("R2", 1, 3, 32'hFFFF); cyc("R2", 0, 3, 0); cyc("R2", 1, 12, 5);
    cyc("R2", 0, 12, 0); cyc("R2", 1, 2, 3); cyc("R2", 0, 4, 0);
    cyc("R2", 1, 6, 32'h55, .low(3)); cyc("R2", 0, 6, 0, .low(2));
    cyc("R2", 0, 15, 0);
    // R3 status bits
    cyc("R3", 0, 2, 0, .dbusy(1)); cyc("R3", 0, 2, 0);
    // R4 full invalidate
    cyc("R4", 1, 4, 2); cyc("R4", 0, 2, 0); cyc("R4", 1, 4, 1); cyc("R4", 0, 2, 0);
    // R6 writes while busy
    cyc("R6", 1, 4, 1); cyc("R6", 1, 5, 32'h77); cyc("R6", 0, 5, 0);
    // R7 completion
    cyc("R7", 0, 2, 0, .done(1)); cyc("R7", 0, 2, 0); cyc("R7", 0, 2, 0, .done(1));
    cyc("R7", 0, 2, 0);
    // R5 page invalidate
    cyc("R5", 1, 5, 32'hFABCDE);
    for (int i = 0; i < 3; i++) cyc("R5", 0, 5, 0);
    cyc("R7", 0, 2, 0, .done(1));
    cyc("R5", 1, 4, 1); cyc("R5", 0, 5, 0);
    cyc("R6", 1, 5, 32'h12345, .done(1)); cyc("R6", 0, 5, 0);
    cyc("R5", 1, 5, 32'h00042); cyc("R5", 0, 5, 0, .done(1)); cyc("R5", 0, 2, 0);
    // R10 counting
    cyc("R10", 1, 8, 1); cyc("R10", 1, 10, 7);
    for (int i = 0; i < 40; i++) cyc("R10", 0, (i % 2) ? 11 : 9, 0, .ev(next_ev()));
    cyc("R10", 1, 10, 3);
    for (int i = 0; i < 30; i++) cyc("R10", 0, (i % 2) ? 9 : 11, 0, .ev(next_ev()));
    cyc("R10", 1, 10, 4);
    for (int i = 0; i < 10; i++) cyc("R10", 0, 11, 0, .ev(4'hF));
    // R11 clears
    cyc("R11", 1, 9, 5, .ev(4'hF)); cyc("R11", 0, 9, 0, .ev(4'hF));
    cyc("R11", 1, 9, 0, .ev(4'hF)); cyc("R11", 0, 9, 0, .ev(4'hF));
    cyc("R11", 1, 8, 1, .ev(4'hF)); cyc("R11", 0, 9, 0, .ev(4'hF));
    // R12 saturation
    cyc("R12", 1, 8, 0);
    for (int i = 0; i < 300; i++) cyc("R12", 0, 9, 0, .ev(4'h1));
    cyc("R12", 1, 9, 0, .ev(4'h1)); cyc("R12", 0, 9, 0, .ev(4'h1));
    finished = 1;
    summary();
    $finish;
  end
endmodule